// File: doc/BRIEF.md
# Host-to-Local Mailbox with Ownership Flags

This block passes bytes and short messages between an external host processor and a local processor. The host uses single-cycle I/O read and write strobes with an address. The local processor uses its own single-cycle register strobes.

A host write to the inbound byte register raises a full flag. That flag is also the interrupt request to the local processor. The same write records whether the byte is data or a command, taken from host address bit 2.

A sixteen-entry two-way buffer can be filled by either side. A write-mode handshake gives one side ownership of it:

- A side claims the buffer by writing entry 0 while the other side holds no claim.
- The claim ends when the opposite side reads the last entry.
- The local processor can also drop its own claim through the status register.
- If both sides claim in the same cycle, the host wins.

Top module: `mbox_handshake`

## Requirements
- R1: After reset every status flag reads 0 from both sides and the interrupt is low. Status layout: bit 0 full, bit 1 user bit, bit 2 command flag, bit 3 host write mode, bit 4 local write mode, other bits 0.
- R2: A host write with address bit 4 = 0 loads the inbound byte register and sets the full flag, and the interrupt follows the full flag. A local read at local address bit 4 = 0, bit 0 = 0 returns that byte and clears the flag.
- R3: Each host write to the inbound byte register copies host address bit 2 into the command flag: 0 for data, 1 for a command.
- R4: When a host write to the inbound byte register and a local read of it fall in the same cycle, the full flag stays 1.
- R5: A host write to buffer entry 0 (host address bit 4 = 1, index 0) sets host write mode while local write mode is 0. A local read of entry 15 clears it.
- R6: A local write to buffer entry 0 sets local write mode while host write mode is 0. The mode clears on a host read of entry 15, or on a local status write (local address bit 4 = 0, bit 0 = 1) with bit 4 = 0. A status write with bit 4 = 1 never sets it.
- R7: When both sides write entry 0 in the same cycle with neither mode held, host write mode is set, local write mode stays 0, and entry 0 holds the host's byte.
- R8: While one side holds write mode, buffer writes from the other side leave the buffer unchanged. Reads from both sides still return the stored contents.
- R9: A local status write sets the user bit from data bit 1, and the host reads it back. No host access changes it.
- R10: When a set event and a clear event for the same mode flag land in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host I/O write strobe |
| host_rd | input | 1 | Host I/O read strobe |
| host_addr | input | 5 | Host address: bit 4 selects the buffer, bits 3:0 are the index; bit 2 is the command flag for inbound writes |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Buffer entry or status register |
| slv_wr | input | 1 | Local write strobe |
| slv_rd | input | 1 | Local read strobe |
| slv_addr | input | 5 | Local address: bit 4 selects the buffer; otherwise bit 0 picks status (1) or the inbound byte (0) |
| slv_wdata | input | 8 | Local write data |
| slv_rdata | output | 8 | Buffer entry, status register or inbound byte |
| slv_irq | output | 1 | Interrupt to the local processor, high while the inbound byte is unread |

## Verification
The inbound path is tried with data-address and command-address writes. This shows that the command flag tracks bit 2 on every write and does not latch once.

The ownership handshake is tried in four patterns:

- A single owner with intruding writes from the other side, which separates a write-protect from a plain priority.
- Each of the three ways a claim is released.
- A same-cycle claim by both sides, which shows whether the host wins.
- Same-cycle set and clear on each flag, which shows set priority over clear.

User-bit writes are mixed with host writes to the status region to show that the host has no path to the user bit.

// File: rtl/mbox_handshake.sv
module mbox_handshake #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [IW:0]   host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          slv_wr,
  input  logic          slv_rd,
  input  logic [IW:0]   slv_addr,
  input  logic [DW-1:0] slv_wdata,
  output logic [DW-1:0] slv_rdata,
  output logic          slv_irq
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
  localparam int B_FULL = 0;
  localparam int B_USR  = 1;
  localparam int B_CMD  = 2;
  localparam int B_HWM  = 3;
  localparam int B_SWM  = 4;

  logic [DW-1:0] inb;
  logic [DW-1:0] mem [DEPTH];
  logic full, usr, cmd, hwm, swm;
  logic [DW-1:0] status;

  wire          h_buf = host_addr[IW];
  wire [IW-1:0] h_idx = host_addr[IW-1:0];
  wire          s_buf = slv_addr[IW];
  wire [IW-1:0] s_idx = slv_addr[IW-1:0];

  wire h_inb_wr  = host_wr & ~h_buf;
  wire h_buf_wr  = host_wr & h_buf;
  wire h_last_rd = host_rd & h_buf & (h_idx == LAST);
  wire s_inb_rd  = slv_rd & ~s_buf & ~slv_addr[0];
  wire s_st_wr   = slv_wr & ~s_buf & slv_addr[0];
  wire s_buf_wr  = slv_wr & s_buf;
  wire s_last_rd = slv_rd & s_buf & (s_idx == LAST);

  wire hwm_set = h_buf_wr & (h_idx == '0) & ~swm;
  wire swm_set = s_buf_wr & (s_idx == '0) & ~hwm & ~hwm_set;
  wire swm_clr = h_last_rd | (s_st_wr & ~slv_wdata[B_SWM]);

  wire h_wr_ok = h_buf_wr & ~swm;
  wire s_wr_ok = s_buf_wr & ~hwm & ~hwm_set & ~(h_wr_ok & (h_idx == s_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      usr  <= 1'b0;
      cmd  <= 1'b0;
      hwm  <= 1'b0;
      swm  <= 1'b0;
      inb  <= '0;
    end else begin
      full <= h_inb_wr | (full & ~s_inb_rd);
      hwm  <= hwm_set | (hwm & ~s_last_rd);
      swm  <= swm_set | (swm & ~swm_clr);
      if (s_st_wr) usr <= slv_wdata[B_USR];
      if (h_inb_wr) begin
        cmd <= host_addr[2];
        inb <= host_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (h_wr_ok) mem[h_idx] <= host_wdata;
      if (s_wr_ok) mem[s_idx] <= slv_wdata;
    end
  end

  always_comb begin
    status         = '0;
    status[B_FULL] = full;
    status[B_USR]  = usr;
    status[B_CMD]  = cmd;
    status[B_HWM]  = hwm;
    status[B_SWM]  = swm;
  end

  assign host_rdata = h_buf ? mem[h_idx] : status;
  assign slv_rdata  = s_buf ? mem[s_idx] : (slv_addr[0] ? status : inb);
  assign slv_irq    = full;

  p_full_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h_inb_wr |=> slv_irq);
  p_full_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_inb_rd && !h_inb_wr |=> !slv_irq);
  p_cmd_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_inb_wr |=> status[B_CMD] == $past(host_addr[2]));
  p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hwm && swm));
  p_host_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    h_buf_wr && s_buf_wr && h_idx == '0 && s_idx == '0 && !hwm && !swm
    |=> hwm && !swm);
  p_no_swm_by_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_st_wr && !swm && !s_buf_wr |=> !swm);
  p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hwm && s_buf_wr && !host_wr |=> mem[$past(s_idx)] == $past(mem[s_idx]));
endmodule

// File: tb/tb_mbox_handshake.sv
module tb_mbox_handshake;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, slv_wr = 0, slv_rd = 0;
  logic [4:0] host_addr = 0, slv_addr = 0;
  logic [7:0] host_wdata = 0, slv_wdata = 0;
  logic [7:0] host_rdata, slv_rdata;
  logic slv_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbox_handshake dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic hw, input logic hr, input logic [4:0] ha, input logic [7:0] hd,
                     input logic sw, input logic sr, input logic [4:0] sa, input logic [7:0] sd);
    @(negedge clk);
    host_wr = hw; host_rd = hr; host_addr = ha; host_wdata = hd;
    slv_wr = sw; slv_rd = sr; slv_addr = sa; slv_wdata = sd;
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0; slv_wr = 0; slv_rd = 0;
  endtask

  task automatic hw_(input logic [4:0] a, input logic [7:0] d); cyc(1,0,a,d,0,0,0,0); endtask
  task automatic sw_(input logic [4:0] a, input logic [7:0] d); cyc(0,0,0,0,1,0,a,d); endtask

  task automatic hread(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); host_rd = 1; host_addr = a; #1 d = host_rdata;
    @(posedge clk); #1 host_rd = 0;
  endtask
  task automatic sread(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); slv_rd = 1; slv_addr = a; #1 d = slv_rdata;
    @(posedge clk); #1 slv_rd = 0;
  endtask
  task automatic hstat(input string tag, input logic [7:0] exp);
    logic [7:0] d; hread(5'h00, d); chk(tag, d, exp);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    hstat("R1 host status", 8'h00);
    sread(5'h01, d); chk("R1 local status", d, 8'h00);
    chk("R1 irq", {7'b0, slv_irq}, 8'h00);
  endtask

  task automatic t_inbound;
    logic [7:0] d;
    hw_(5'h00, 8'hA5);
    chk("R2 irq set", {7'b0, slv_irq}, 8'h01);
    hstat("R2 R3 full data", 8'h01);
    sread(5'h00, d); chk("R2 byte", d, 8'hA5);
    chk("R2 irq clear", {7'b0, slv_irq}, 8'h00);
    hw_(5'h04, 8'h3C); hstat("R3 command", 8'h05);
    hw_(5'h00, 8'h3D); hstat("R3 back to data", 8'h01);
    cyc(1,0,5'h04,8'h77, 0,1,5'h00,0);
    hstat("R4 set beats clear", 8'h05);
    sread(5'h00, d); chk("R4 newest byte", d, 8'h77);
    hstat("R2 cleared", 8'h04);
  endtask

  task automatic t_host_mode;
    logic [7:0] d;
    hw_(5'h10, 8'h11); hstat("R5 host mode set", 8'h0C);
    sw_(5'h13, 8'h99); hread(5'h13, d); chk("R8 local write blocked", d, 8'h00);
    sw_(5'h10, 8'h98); sread(5'h10, d); chk("R8 entry0 kept", d, 8'h11);
    hstat("R6 no local mode while host holds", 8'h0C);
    hw_(5'h13, 8'h33); sread(5'h13, d); chk("R8 local read allowed", d, 8'h33);
    cyc(1,0,5'h10,8'h12, 0,1,5'h1F,0);
    hstat("R10 host mode set beats clear", 8'h0C);
    sread(5'h1F, d); hstat("R5 host mode cleared", 8'h04);
  endtask

  task automatic t_slave_mode;
    logic [7:0] d;
    sw_(5'h01, 8'h10); hstat("R6 write 1 no effect", 8'h04);
    sw_(5'h10, 8'h22); hstat("R6 local mode set", 8'h14);
    hw_(5'h15, 8'h55); sread(5'h15, d); chk("R8 host write blocked", d, 8'h00);
    hw_(5'h10, 8'h56); hstat("R5 no host mode while local holds", 8'h14);
    hread(5'h10, d); chk("R8 host read allowed", d, 8'h22);
    sw_(5'h01, 8'h10); hstat("R6 write 1 keeps", 8'h14);
    cyc(0,1,5'h1F,0, 1,0,5'h10,8'h23);
    hstat("R10 local mode set beats clear", 8'h14);
    hread(5'h1F, d); hstat("R6 cleared by host read 15", 8'h04);
    sw_(5'h10, 8'h24); hstat("R6 set again", 8'h14);
    sw_(5'h01, 8'h00); hstat("R6 cleared by write 0", 8'h04);
  endtask

  task automatic t_user;
    logic [7:0] d;
    sw_(5'h01, 8'h12); hstat("R9 user set", 8'h06);
    hw_(5'h08, 8'hFF); hstat("R9 host write no effect", 8'h03);
    sread(5'h00, d); chk("R9 byte", d, 8'hFF);
    sw_(5'h01, 8'h00); hstat("R9 user clear", 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    cyc(1,0,5'h10,8'hAA, 1,0,5'h10,8'hBB);
    hstat("R7 host wins", 8'h08);
    sread(5'h10, d); chk("R7 host byte", d, 8'hAA);
    sread(5'h1F, d); hstat("R5 released", 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_inbound; t_host_mode; t_slave_mode; t_user; t_collide;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule